// File: doc/BRIEF.md
# Event Timestamp Capture Unit

This unit timestamps external events against a free-running counter. A chosen edge on the event input copies the counter value into a capture register. The event comes either from a dedicated input pin or from the output of an analog comparator. The event passes through a two-stage synchronizer. It can then go through a majority-free noise filter, which accepts a new level only after several equal samples in a row. Each capture sets a sticky flag. When an enable is set, the flag drives an interrupt request.

The capture register can instead hold the counter's TOP value. In that mode, events never overwrite it and never raise the flag. A write port loads the register in either mode. Software can then compute periods and duty cycles from successive stamps, or use the register as a period limit for a counter kept outside the unit.

Top module: `evt_capture`

## Requirements
- R1: After reset, cap_val_o is 0, flag_o is 0 and irq_o is 0.
- R2: With the filter off, `edge_rise_i`=1 and `top_mode_i`=0, suppose the selected event input rises in the clock cycle before rising clock edge k. The register then loads the count_i value present between edges k+1 and k+2, and shows it after edge k+2.
- R3: When `edge_rise_i`=0, only falling edges cause captures, with the same latency as R2. When `edge_rise_i`=1, falling edges are ignored.
- R4: When `src_cmp_i`=1, the event is taken from cmp_evt_i and pin_evt_i has no effect. When `src_cmp_i`=0, the event is taken from pin_evt_i and cmp_evt_i has no effect.
- R5: When `filt_en_i`=1, a level is accepted only after 4 consecutive equal synchronized samples. This adds 4 cycles to the R2 latency. A pulse of 3 cycles or less causes no capture.
- R6: Every capture event sets flag_o on the following edge. flag_o stays set until flag_clr_i is high at an edge. If a capture and a clear coincide, the capture wins.
- R7: irq_o is high exactly when flag_o and irq_en_i are both high.
- R8: When `top_mode_i`=1, events neither change cap_val_o nor set flag_o.
- R9: When `wr_en_i` is high at an edge, cap_val_o takes wr_data_i, in any mode. A write overrides a capture in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| count_i | input | 16 | Free-running counter value to stamp |
| pin_evt_i | input | 1 | Event from dedicated pin (asynchronous) |
| cmp_evt_i | input | 1 | Event from analog comparator (asynchronous) |
| src_cmp_i | input | 1 | Source select: 1 comparator, 0 pin |
| edge_rise_i | input | 1 | Edge select: 1 rising, 0 falling |
| filt_en_i | input | 1 | Enable the noise filter |
| top_mode_i | input | 1 | Register reserved as counter TOP; capture off |
| wr_en_i | input | 1 | Load the register from wr_data_i |
| wr_data_i | input | 16 | Value to load |
| flag_clr_i | input | 1 | Clear the capture flag |
| irq_en_i | input | 1 | Interrupt enable |
| cap_val_o | output | 16 | Capture register / TOP value |
| flag_o | output | 1 | Capture flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that the source select and the filter enable change only while the two candidate levels agree. Without that, a switch would create a false edge that no property accounts for. The stimulus changes those controls only when both event inputs and the filtered level all sit low. It also changes the event inputs only at falling clock edges, so each capture falls in a cycle that can be predicted exactly.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic {SRC_PIN = 1'b0, SRC_CMP = 1'b1} evt_src_e;
  localparam int unsigned SYNC_STAGES_DEF = 2;
  localparam int unsigned FILT_LEN_DEF    = 4;
endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q[0] <= 1'b0;
    else         sr_q[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sr_q[i] <= 1'b0;
      else         sr_q[i] <= sr_q[i-1];
    end
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/cap_filter.sv
module cap_filter #(
  parameter int unsigned LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic filt_o
);
  localparam int unsigned HW = LEN - 1;

  logic [HW-1:0] hist_q;
  logic          all_hi, all_lo;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else         hist_q <= {hist_q[HW-2:0], in_i};
  end

  assign all_hi = in_i & (&hist_q);
  assign all_lo = ~in_i & ~(|hist_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     filt_o <= 1'b0;
    else if (all_hi) filt_o <= 1'b1;
    else if (all_lo) filt_o <= 1'b0;
  end

  // output may only move toward the level just sampled
  AST_FILT_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(filt_o) |-> ($past(in_i) == filt_o)); // R5
endmodule

// File: rtl/cap_edge.sv
module cap_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic rise_sel_i,
  output logic evt_o
);
  logic prev_q, rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise  = lvl_i & ~prev_q;
  assign fall  = ~lvl_i & prev_q;
  assign evt_o = rise_sel_i ? rise : fall;
endmodule

// File: rtl/evt_capture.sv
module evt_capture
  import cap_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF,
  parameter int unsigned FILT_LEN    = FILT_LEN_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] count_i,
  input  logic             pin_evt_i,
  input  logic             cmp_evt_i,
  input  logic             src_cmp_i,
  input  logic             edge_rise_i,
  input  logic             filt_en_i,
  input  logic             top_mode_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             flag_clr_i,
  input  logic             irq_en_i,
  output logic [CNT_W-1:0] cap_val_o,
  output logic             flag_o,
  output logic             irq_o
);
  evt_src_e   src;
  logic       raw_evt, sync_lvl, filt_lvl, lvl, edge_evt, cap_evt;

  assign src     = evt_src_e'(src_cmp_i);
  assign raw_evt = (src == SRC_CMP) ? cmp_evt_i : pin_evt_i;

  cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw_evt), .q_o(sync_lvl)
  );

  cap_filter #(.LEN(FILT_LEN)) u_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_i(sync_lvl), .filt_o(filt_lvl)
  );

  assign lvl = filt_en_i ? filt_lvl : sync_lvl;

  cap_edge u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(lvl),
    .rise_sel_i(edge_rise_i), .evt_o(edge_evt)
  );

  assign cap_evt = edge_evt & ~top_mode_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cap_val_o <= '0;
    else if (wr_en_i) cap_val_o <= wr_data_i;
    else if (cap_evt) cap_val_o <= count_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_o <= 1'b0;
    else if (cap_evt)    flag_o <= 1'b1;
    else if (flag_clr_i) flag_o <= 1'b0;
  end

  assign irq_o = flag_o & irq_en_i;

  AST_CAP_STAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_evt && !top_mode_i && !wr_en_i) |=> (cap_val_o == $past(count_i))); // R2
  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_evt && !top_mode_i) |=> flag_o); // R6
  AST_FLAG_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(edge_evt && !top_mode_i)); // R6
  AST_TOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (top_mode_i && !wr_en_i) |=> ($stable(cap_val_o) && !$rose(flag_o))); // R8
  AST_WR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (cap_val_o == $past(wr_data_i))); // R9
endmodule

// File: tb/sim_evt_capture.sv
module sim_evt_capture;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [15:0] cnt;
  logic        pin = 0, cmp = 0, src_cmp = 0, rise = 1, filt = 0, top = 0;
  logic        wr = 0, clr = 0, irq_en = 0;
  logic [15:0] wdata = '0;
  logic [15:0] cap_val;
  logic        flag, irq;

  int checks = 0, fails = 0;

  typedef struct { logic [15:0] v; string tag; } exp_t;
  exp_t        sb[$];
  logic [15:0] last_cap = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0; else cnt <= cnt + 16'd1;

  evt_capture u0 (
    .clk_i(clk), .rst_ni(rst_n), .count_i(cnt), .pin_evt_i(pin),
    .cmp_evt_i(cmp), .src_cmp_i(src_cmp), .edge_rise_i(rise),
    .filt_en_i(filt), .top_mode_i(top), .wr_en_i(wr), .wr_data_i(wdata),
    .flag_clr_i(clr), .irq_en_i(irq_en), .cap_val_o(cap_val),
    .flag_o(flag), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] v, input string tag);
    exp_t e;
    e.v = v; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: every change of the register must match the next expected item
  always @(negedge clk) begin
    if (rst_n && cap_val !== last_cap) begin
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL unexpected capture (R3/R4/R5/R8): actual %0h expected %0h", cap_val, last_cap);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (cap_val !== e.v) begin
          fails++;
          $display("FAIL %s: actual %0h expected %0h", e.tag, cap_val, e.v);
        end
      end
      last_cap = cap_val;
    end
  end

  task automatic clear_flag();
    clr = 1; tick(1); clr = 0;
  endtask

  initial begin
    tick(2);
    chk("R1 cap", cap_val, 0); chk("R1 flag", flag, 0); chk("R1 irq", irq, 0);
    rst_n = 1; tick(3);

    // R2 rising capture
    pin = 1; push(cnt + 16'd2, "R2 rise stamp"); tick(6);
    chk("R6 flag set", flag, 1);
    chk("R7 irq masked", irq, 0);
    irq_en = 1; #1 chk("R7 irq on", irq, 1);
    tick(1); clear_flag(); #1;
    chk("R6 flag cleared", flag, 0); chk("R7 irq off", irq, 0);

    // R3 falling ignored while rising selected
    pin = 0; tick(6); chk("R3 fall ignored", flag, 0);

    // R3 falling edge mode
    rise = 0; tick(2);
    pin = 1; tick(6); chk("R3 rise ignored", flag, 0);
    pin = 0; push(cnt + 16'd2, "R3 fall stamp"); tick(6);
    chk("R3 flag", flag, 1); clear_flag();

    // R4 comparator source
    src_cmp = 1; tick(4);
    pin = 1; tick(4); pin = 0; tick(6); chk("R4 pin ignored", flag, 0);
    cmp = 1; tick(6); cmp = 0; push(cnt + 16'd2, "R4 cmp stamp"); tick(6);
    chk("R4 flag", flag, 1); clear_flag();
    src_cmp = 0; rise = 1; tick(4);
    cmp = 1; tick(6); chk("R4 cmp ignored", flag, 0); cmp = 0; tick(4);

    // R5 filter
    filt = 1; tick(6);
    pin = 1; tick(3); pin = 0; tick(10); chk("R5 short pulse", flag, 0);
    pin = 1; push(cnt + 16'd6, "R5 filtered stamp"); tick(10);
    chk("R5 flag", flag, 1); clear_flag();
    pin = 0; tick(10); filt = 0; tick(2);

    // R6 capture wins over clear in the same cycle
    pin = 1; push(cnt + 16'd2, "R6 stamp"); tick(2);
    clr = 1; tick(1); clr = 0;
    chk("R6 set beats clear", flag, 1); clear_flag();
    pin = 0; tick(6);

    // R8 reserved as TOP
    top = 1; tick(2);
    pin = 1; tick(6); chk("R8 no flag", flag, 0);
    pin = 0; tick(4);
    // R9 write in TOP mode
    wr = 1; wdata = 16'hBEEF; push(16'hBEEF, "R9 write"); tick(1); wr = 0;
    chk("R8 irq idle", irq, 0);
    top = 0; tick(4);
    // R9 write collides with capture
    pin = 1; tick(2);
    wr = 1; wdata = 16'h1234; push(16'h1234, "R9 write wins"); tick(1); wr = 0;
    tick(4);
    chk("R9 scoreboard drained", sb.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule